// File: doc/BRIEF.md
# Configurable-Mode SPI Master

This block is a full-duplex serial master for a single peripheral. Each frame shifts one word out on `mosi` while it collects one word from `miso`. The peripheral is selected by one active-low select line. The clock idle level, the capture phase, the bit order, the frame length (4 to 32 bits) and the clock rate can all be programmed. The clock rate is the system clock divided by a power of two from 2 to 256.

Software first programs the settings and sets the enable bit through a one-cycle configuration strobe. It then hands over words with a valid/ready handshake. Each completed frame returns the received word right-justified, together with a one-cycle done pulse. Mode, order, length and rate are frozen while the enable bit is set or a frame is on the wire. To change them, clear the enable bit, write the new settings, then enable again.

Top module: `spim_master`

## Requirements
- R1: After synchronous reset `cs_n`=1, `sck`=0, `mosi`=0, `rx_done`=0, `tx_ready`=0 and `rx_data`=0. The reset settings are idle-low clock, first-edge capture, MSB-first, 8-bit frames and divide-by-256.
- R2: While `cs_n` is high, `sck` rests at the stored polarity (`cfg_cpol`: 0 = low, 1 = high). It is back at that level between frames.
- R3: With `cfg_cpha`=0, the first data bit is on `mosi` when `cs_n` falls. `miso` is captured on the 1st, 3rd, 5th… transitions of `sck` away from rest, and `mosi` moves on the even transitions. With `cfg_cpha`=1, `mosi` moves on odd transitions and capture happens on even ones. For modes 0 to 3, the capture transitions are rising, falling, falling and rising.
- R4: `cfg_len_m1` holds the frame length minus one. A frame of N bits makes exactly 2N `sck` transitions. Codes 0 to 2 are stored as 3, which gives a 4-bit frame.
- R5: `cfg_div_sel`=s gives a half period of 2^s system clocks, so the `sck` period is 2^(s+1) clocks.
- R6: `cs_n` falls one half period before the first `sck` transition and rises one half period after the last one.
- R7: With `cfg_lsb_first`=0, bit N-1 is sent and received first. With `cfg_lsb_first`=1, bit 0 goes first. As an example, 0xC0 sent LSB-first and assembled MSB-first reads back as 0x03.
- R8: `rx_data` holds the received N bits in bits N-1..0, with all higher bits zero. `tx_data` bits at N and above are never sent. `rx_done` is high for exactly one cycle, in the same cycle that `cs_n` rises, and `rx_data` is valid then.
- R9: A `cfg_we` strobe always stores `cfg_enable`. It updates polarity, phase, order, length and divider only if the stored enable was clear and no frame was active; otherwise those fields keep their values.
- R10: `tx_ready` is high only when enabled and idle. A frame starts on the cycle where `tx_valid` and `tx_ready` are both high. While disabled, `tx_valid` causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cpol | input | 1 | Clock rest level |
| cfg_cpha | input | 1 | 0: capture on first transition, 1: on second |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: top bit first |
| cfg_len_m1 | input | LEN_W (5) | Frame length minus one |
| cfg_div_sel | input | DSEL_W (3) | Divider exponent, divide by 2^(s+1) |
| cfg_enable | input | 1 | Enable bit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word accepted when high with valid |
| tx_data | input | DATA_W (32) | Word to send, right-justified |
| rx_data | output | DATA_W (32) | Last received word, right-justified |
| rx_done | output | 1 | One-cycle pulse at frame end |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low peripheral select |
| miso | input | 1 | Serial data in |

## Verification
The hardest situation to reach from the ports is a configuration write that arrives while a frame is on the wire. In that case the enable bit clears at once but every timing field must hold. The stimulus issues a conflicting write a few cycles into a long, slow frame. It then confirms three things at the pins: the frame still completes in its original shape, the clock still rests at the old level afterwards, and no new frame can start. A behavioural peripheral samples and drives according to the mode the bench believes is active. It is swept over all four modes, both orders, several lengths and three dividers, plus the 256 divider and the 4-bit clamp. A deliberate order mismatch checks the bit-reversed result.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned SPIM_MAX_BITS = 32;
  localparam int unsigned SPIM_DSEL_W   = 3;
  localparam int unsigned SPIM_MIN_BITS = 4;
  localparam int unsigned SPIM_DEF_BITS = 8;

  typedef enum logic [1:0] {
    SPIM_IDLE  = 2'd0,
    SPIM_RUN   = 2'd1,
    SPIM_TRAIL = 2'd2
  } spim_state_e;
endpackage

// File: rtl/spim_cfg_reg.sv
module spim_cfg_reg #(
  parameter int unsigned LEN_W    = 5,
  parameter int unsigned DSEL_W   = 3,
  parameter int unsigned MIN_BITS = 4,
  parameter int unsigned DEF_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              wr_cpol,
  input  logic              wr_cpha,
  input  logic              wr_lsb,
  input  logic [LEN_W-1:0]  wr_len_m1,
  input  logic [DSEL_W-1:0] wr_dsel,
  input  logic              wr_en,
  input  logic              bus_idle,
  output logic              cpol,
  output logic              cpha,
  output logic              lsb,
  output logic [LEN_W-1:0]  len_m1,
  output logic [DSEL_W-1:0] dsel,
  output logic              en
);
  localparam logic [LEN_W-1:0] MIN_M1 = LEN_W'(MIN_BITS - 1);
  localparam logic [LEN_W-1:0] DEF_M1 = LEN_W'(DEF_BITS - 1);

  logic open_for_write;
  assign open_for_write = !en && bus_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpol   <= 1'b0;
      cpha   <= 1'b0;
      lsb    <= 1'b0;
      len_m1 <= DEF_M1;
      dsel   <= '1;
      en     <= 1'b0;
    end else if (wr_stb) begin
      en <= wr_en;
      if (open_for_write) begin
        cpol   <= wr_cpol;
        cpha   <= wr_cpha;
        lsb    <= wr_lsb;
        len_m1 <= (wr_len_m1 < MIN_M1) ? MIN_M1 : wr_len_m1;
        dsel   <= wr_dsel;
      end
    end
  end

  // R9: timing fields frozen while a frame is active
  assert_lock_busy_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_idle |=> $stable({cpol, cpha, lsb, len_m1, dsel}));
  // R9: timing fields frozen while enabled
  assert_lock_en_R9: assert property (@(posedge clk) disable iff (rst)
    en |=> $stable({cpol, cpha, lsb, len_m1, dsel}));
  // R4: stored length never below the minimum
  assert_len_floor_R4: assert property (@(posedge clk) disable iff (rst)
    len_m1 >= MIN_M1);
endmodule

// File: rtl/spim_tick.sv
module spim_tick #(
  parameter int unsigned DSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DSEL_W-1:0] dsel,
  output logic              tick
);
  localparam int unsigned CNT_W = (1 << DSEL_W) - 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;

  assign half_m1 = (ONE << dsel) - ONE;
  assign tick    = run && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else cnt <= cnt + ONE;
  end

  // R5: the half-period counter stays inside the selected window
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt <= half_m1);
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              lsb,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              shift_en,
  input  logic [LEN_W-1:0]  shift_idx,
  input  logic              sample_en,
  input  logic [LEN_W-1:0]  sample_idx,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_word;
  logic [LEN_W-1:0]  pos_first, pos_shift, pos_sample;

  // Order-dependent mapping from wire bit number to word bit position
  assign pos_first  = lsb ? '0 : len_m1;
  assign pos_shift  = lsb ? shift_idx  : (len_m1 - shift_idx);
  assign pos_sample = lsb ? sample_idx : (len_m1 - sample_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word <= '0;
      rx_word <= '0;
      mosi    <= 1'b0;
    end else if (load) begin
      tx_word <= tx_data;
      rx_word <= '0;
      mosi    <= tx_data[pos_first];
    end else begin
      if (shift_en)  mosi <= tx_word[pos_shift];
      if (sample_en) rx_word[pos_sample] <= miso;
    end
  end

  // R8: a new frame starts from an empty receive word
  assert_rx_clear_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> rx_word == '0);
endmodule

// File: rtl/spim_master.sv
module spim_master import spim_pkg::*; #(
  parameter int unsigned DATA_W   = SPIM_MAX_BITS,
  parameter int unsigned LEN_W    = $clog2(DATA_W),
  parameter int unsigned DSEL_W   = SPIM_DSEL_W,
  parameter int unsigned MIN_BITS = SPIM_MIN_BITS,
  parameter int unsigned DEF_BITS = SPIM_DEF_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic [DSEL_W-1:0] cfg_div_sel,
  input  logic              cfg_enable,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso
);
  localparam int unsigned ECNT_W = LEN_W + 1;

  spim_state_e       state;
  logic              cpol, cpha, lsb, en;
  logic [LEN_W-1:0]  len_m1;
  logic [DSEL_W-1:0] dsel;
  logic              tick, run, in_run, accept;
  logic              sample_en, shift_en;
  logic [ECNT_W-1:0] ecnt, ecnt_nx, last_edge;
  logic [DATA_W-1:0] rx_word;

  spim_cfg_reg #(
    .LEN_W(LEN_W), .DSEL_W(DSEL_W), .MIN_BITS(MIN_BITS), .DEF_BITS(DEF_BITS)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_stb(cfg_we),
    .wr_cpol(cfg_cpol), .wr_cpha(cfg_cpha), .wr_lsb(cfg_lsb_first),
    .wr_len_m1(cfg_len_m1), .wr_dsel(cfg_div_sel), .wr_en(cfg_enable),
    .bus_idle(state == SPIM_IDLE),
    .cpol(cpol), .cpha(cpha), .lsb(lsb), .len_m1(len_m1), .dsel(dsel), .en(en)
  );

  spim_tick #(.DSEL_W(DSEL_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .dsel(dsel), .tick(tick)
  );

  assign run       = (state != SPIM_IDLE);
  assign in_run    = (state == SPIM_RUN);
  assign tx_ready  = en && (state == SPIM_IDLE);
  assign accept    = tx_valid && tx_ready;
  assign last_edge = {len_m1, 1'b1};
  assign ecnt_nx   = ecnt + 1'b1;
  // Edge m (0-based): capture when m is even for phase 0, odd for phase 1
  assign sample_en = in_run && tick && (ecnt[0] == cpha);
  assign shift_en  = in_run && tick && (ecnt[0] != cpha) && (ecnt != last_edge);

  spim_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst(rst), .load(accept), .tx_data(tx_data),
    .lsb(lsb), .len_m1(len_m1),
    .shift_en(shift_en), .shift_idx(ecnt_nx[ECNT_W-1:1]),
    .sample_en(sample_en), .sample_idx(ecnt[ECNT_W-1:1]),
    .miso(miso), .mosi(mosi), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SPIM_IDLE;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
      ecnt    <= '0;
      rx_done <= 1'b0;
      rx_data <= '0;
    end else begin
      rx_done <= 1'b0;
      case (state)
        SPIM_IDLE: begin
          sck  <= cpol;
          cs_n <= 1'b1;
          ecnt <= '0;
          if (accept) begin
            cs_n  <= 1'b0;
            state <= SPIM_RUN;
          end
        end
        SPIM_RUN: begin
          if (tick) begin
            sck  <= ~sck;
            ecnt <= ecnt_nx;
            if (ecnt == last_edge) state <= SPIM_TRAIL;
          end
        end
        SPIM_TRAIL: begin
          if (tick) begin
            cs_n    <= 1'b1;
            rx_done <= 1'b1;
            rx_data <= rx_word;
            state   <= SPIM_IDLE;
          end
        end
        default: state <= SPIM_IDLE;
      endcase
    end
  end

  // R10: a word is only offered for acceptance while the bus is quiet
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> cs_n);
  // R8: completion pulse lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);
  // R8: completion coincides with select release
  assert_done_cs_R8: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> $rose(cs_n));
  // R2: clock rests at the stored polarity while deselected
  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $stable(cpol)) |-> sck == cpol);
  // R4: an even number of transitions brings the clock back to rest
  assert_trail_level_R4: assert property (@(posedge clk) disable iff (rst)
    (state == SPIM_TRAIL) |-> sck == cpol);
endmodule

// File: tb/sim_spim_master.sv
module sim_spim_master;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0, cfg_en = 1'b0;
  logic [4:0]  cfg_len = 5'd7;
  logic [2:0]  cfg_div = 3'd0;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic [31:0] rx_data;
  logic        tx_ready, rx_done, sck, mosi, cs_n;
  logic        miso = 1'b0;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  spim_master u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb), .cfg_len_m1(cfg_len), .cfg_div_sel(cfg_div),
    .cfg_enable(cfg_en), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_data(rx_data), .rx_done(rx_done), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .miso(miso)
  );

  // Behavioural peripheral and pin monitor, evaluated between clock edges
  logic        m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
  int          m_n = 8;
  logic        prev_sck = 1'b0, prev_cs = 1'b1;
  int          edges = 0, cnt = 0, lead_meas = 0, trail_meas = 0, dir_bad = 0, idle_bad = 0;
  logic        idle_chk = 1'b0;
  logic [31:0] slv_tx = '0, slv_rx = '0;

  function automatic int bpos(input int j);
    return m_lsb ? j : (m_n - 1 - j);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !cs_n) begin
        edges = 0; cnt = 0; slv_rx = '0; dir_bad = 0;
        if (!m_cpha) miso = slv_tx[bpos(0)];
      end else if (!prev_cs && !cs_n) begin
        cnt++;
        if (sck !== prev_sck) begin
          if (edges == 0) lead_meas = cnt;
          cnt = 0;
          if (((edges % 2) == 0) == (m_cpha == 1'b0)) begin
            slv_rx[bpos(edges / 2)] = mosi;
            if (sck !== ~(m_cpol ^ m_cpha)) dir_bad++;
          end else if (((edges + 1) / 2) < m_n) begin
            miso = slv_tx[bpos((edges + 1) / 2)];
          end
          edges++;
        end
      end else if (!prev_cs && cs_n) begin
        cnt++;
        trail_meas = cnt;
      end else if (idle_chk && (sck !== m_cpol)) begin
        idle_bad++;
      end
    end
    prev_sck = sck;
    prev_cs  = cs_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic p, input logic h, input logic l,
                           input logic [4:0] len, input logic [2:0] dv, input logic e);
    @(negedge clk);
    cfg_cpol = p; cfg_cpha = h; cfg_lsb = l; cfg_len = len; cfg_div = dv; cfg_en = e;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic p, input logic h, input logic l,
                       input logic [4:0] len, input logic [2:0] dv);
    idle_chk = 1'b0;
    cfg_write(p, h, l, len, dv, 1'b0);
    cfg_write(p, h, l, len, dv, 1'b0);
    cfg_write(p, h, l, len, dv, 1'b1);
    m_cpol = p; m_cpha = h; m_lsb = l;
    m_n = ((len < 5'd3) ? 3 : int'(len)) + 1;
    repeat (2) @(negedge clk);
    idle_chk = 1'b1;
  endtask

  function automatic logic [31:0] mask_of(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic run_frame(input logic [31:0] tx, input logic [31:0] stx,
                           input logic [31:0] exp_s, input logic [31:0] exp_r,
                           input int h, input logic mid_write);
    int w;
    chk("R2 sck rest level before frame", {31'b0, sck}, {31'b0, m_cpol});
    slv_tx = stx;
    @(negedge clk);
    tx_valid = 1'b1; tx_data = tx;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R10 cs_n low after handshake", {31'b0, cs_n}, 32'd0);
    if (mid_write) begin
      repeat (3) @(negedge clk);
      cfg_write(~m_cpol, ~m_cpha, ~m_lsb, 5'd3, 3'd0, 1'b0);
      cfg_write(~m_cpol, ~m_cpha, ~m_lsb, 5'd3, 3'd0, 1'b0);
    end
    w = 0;
    while (!rx_done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk("R8 rx_done seen", {31'b0, rx_done}, 32'd1);
    chk("R8 rx_data right-justified", rx_data, exp_r);
    @(negedge clk);
    chk("R8 rx_done one cycle", {31'b0, rx_done}, 32'd0);
    #1;
    chk("R3 R7 peripheral captured word", slv_rx, exp_s);
    chk("R4 sck transitions per frame", edges, 2 * m_n);
    chk("R5 R6 select lead half period", lead_meas, h);
    chk("R6 select trail half period", trail_meas, h);
    chk("R3 capture edge direction", dir_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] tx, stx, mk;
    int k;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", {31'b0, cs_n}, 32'd1);
    chk("R1 sck", {31'b0, sck}, 32'd0);
    chk("R1 mosi", {31'b0, mosi}, 32'd0);
    chk("R1 rx_done", {31'b0, rx_done}, 32'd0);
    chk("R1 tx_ready", {31'b0, tx_ready}, 32'd0);
    chk("R1 rx_data", rx_data, 32'd0);

    // R10: disabled block ignores an offered word
    begin
      int seen = 0;
      tx_valid = 1'b1; tx_data = 32'h1234_5678;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!cs_n || tx_ready) seen++;
      end
      tx_valid = 1'b0;
      chk("R10 no activity while disabled", seen, 0);
    end

    // Sweep: modes x lengths x order x dividers
    k = 0;
    for (int md = 0; md < 4; md++) begin
      for (int li = 0; li < 5; li++) begin
        for (int ob = 0; ob < 2; ob++) begin
          for (int di = 0; di < 3; di++) begin
            int lens[5] = '{3, 6, 7, 15, 31};
            int divs[3] = '{0, 1, 3};
            setup(md[1], md[0], ob[0], 5'(lens[li]), 3'(divs[di]));
            tx  = 32'hA5C3_1E97 ^ (32'(k) * 32'h9E37_79B9);
            stx = 32'h0123_4567 + (32'(k) * 32'h6D2B_79F5);
            mk  = mask_of(m_n);
            run_frame(tx, stx, tx & mk, stx & mk, 1 << divs[di], 1'b0);
            k++;
          end
        end
      end
    end

    // R4: short length codes clamp to a 4-bit frame
    setup(1'b0, 1'b1, 1'b0, 5'd1, 3'd1);
    run_frame(32'hFFFF_FFF5, 32'h0000_000A, 32'h5, 32'hA, 2, 1'b0);

    // R5: slowest divider, mode 3
    setup(1'b1, 1'b1, 1'b0, 5'd7, 3'd7);
    run_frame(32'h0000_005A, 32'h0000_00C3, 32'h5A, 32'hC3, 128, 1'b0);

    // R7: LSB-first sender seen by an MSB-first receiver
    setup(1'b0, 1'b0, 1'b1, 5'd7, 3'd0);
    m_lsb = 1'b0;
    run_frame(32'h0000_00C0, 32'h0000_0003, 32'h0000_0003, 32'h0000_00C0, 1, 1'b0);

    // R9: write while enabled is ignored (order stays MSB-first)
    setup(1'b0, 1'b0, 1'b0, 5'd7, 3'd0);
    cfg_write(1'b1, 1'b1, 1'b1, 5'd15, 3'd2, 1'b1);
    repeat (2) @(negedge clk);
    run_frame(32'h0000_00C0, 32'h0000_0081, 32'h0000_00C0, 32'h0000_0081, 1, 1'b0);

    // R9: writes during an active frame leave the timing fields alone
    setup(1'b0, 1'b0, 1'b0, 5'd15, 3'd2);
    run_frame(32'h0000_BEEF, 32'h0000_1357, 32'h0000_BEEF, 32'h0000_1357, 4, 1'b1);
    repeat (4) @(negedge clk);
    chk("R9 rest level unchanged after busy write", {31'b0, sck}, 32'd0);
    chk("R10 enable cleared by busy write", {31'b0, tx_ready}, 32'd0);

    chk("R2 no rest-level violations", idle_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule